// File: doc/BRIEF.md
# General-Purpose Register File with Operand Selection

This block stores the fifteen 64-bit general registers of a simple sequential processor. It also works out which registers each instruction reads and writes. Each cycle it takes the 4-bit instruction code, the two 4-bit register fields of the instruction and the condition result from the execute stage. From these it derives two read selections and two write selections.

The two read ports are combinational, so operand values are ready in the same cycle as the instruction. The two write ports, one carrying the ALU result and one carrying the loaded memory word, update the array on the rising clock edge. Register ID 0xF stands for "no register". Stack instructions use register 4 as the stack pointer without naming it in a field. A conditional move writes its destination only when the condition input is high.

Top module: `gpr_file_sel`

## Requirements
- R1: After reset every register 0..14 reads as zero.
- R2: Reading register ID 0xF returns zero, and a write aimed at ID 0xF changes no register.
- R3: Read port A selects `fld_a` for codes 0x2, 0x4, 0x6 and 0xA. It selects register 4 for codes 0x9 and 0xB, and 0xF for all other codes.
- R4: Read port B selects `fld_b` for codes 0x4, 0x5 and 0x6. It selects register 4 for codes 0x8, 0x9, 0xA and 0xB, and 0xF for all other codes.
- R5: Both reads are combinational, so a change of code or fields shows on `rdata_a`/`rdata_b` in the same cycle. A write becomes visible right after the rising edge that performs it.
- R6: Write port E stores `wdata_e` into `fld_b` for codes 0x3 and 0x6. It stores into `fld_b` for code 0x2 only when `cond_ok` is 1. It stores into register 4 for codes 0x8, 0x9, 0xA and 0xB. Any other code performs no E write.
- R7: Write port M stores `wdata_m` into `fld_a` for codes 0x5 and 0xB. Any other code performs no M write.
- R8: When both write ports target the same register in one cycle, that register takes `wdata_m`.
- R9: Registers that neither write port targets in a cycle keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; writes happen on the rising edge |
| rst_n | input | 1 | Active-low asynchronous reset, clears all registers |
| op_code | input | 4 | Instruction code of the current instruction |
| fld_a | input | 4 | First register field of the instruction |
| fld_b | input | 4 | Second register field of the instruction |
| cond_ok | input | 1 | Condition result gating the conditional move |
| wdata_e | input | 64 | ALU result for write port E |
| wdata_m | input | 64 | Memory word for write port M |
| rdata_a | output | 64 | Value from read port A |
| rdata_b | output | 64 | Value from read port B |

## Verification
Read results are due zero cycles after the inputs change. Register writes are due one rising edge later. The bench therefore drives each instruction just after a falling edge and samples both read ports a few nanoseconds later, in the same cycle. A write is checked by a read in a later cycle, made with a read-only probe instruction (code 0x4). The bench's reference array is updated only after the reads of that cycle have been compared, so each expected value reflects exactly the edges that have already occurred.

// File: rtl/gprf_pkg.sv
package gprf_pkg;

  typedef logic [3:0] reg_id_t;

  localparam reg_id_t ID_NONE = 4'hF;
  localparam reg_id_t SP_ID   = 4'h4;

  localparam logic [3:0] OP_HALT = 4'h0;
  localparam logic [3:0] OP_NOP  = 4'h1;
  localparam logic [3:0] OP_MOVC = 4'h2;
  localparam logic [3:0] OP_LDI  = 4'h3;
  localparam logic [3:0] OP_STM  = 4'h4;
  localparam logic [3:0] OP_LDM  = 4'h5;
  localparam logic [3:0] OP_ALU  = 4'h6;
  localparam logic [3:0] OP_JMP  = 4'h7;
  localparam logic [3:0] OP_CALL = 4'h8;
  localparam logic [3:0] OP_RET  = 4'h9;
  localparam logic [3:0] OP_PUSH = 4'hA;
  localparam logic [3:0] OP_POP  = 4'hB;

  function automatic reg_id_t pick_src_a(logic [3:0] op, reg_id_t fa);
    case (op)
      OP_MOVC, OP_STM, OP_ALU, OP_PUSH: return fa;
      OP_RET, OP_POP:                   return SP_ID;
      default:                          return ID_NONE;
    endcase
  endfunction

  function automatic reg_id_t pick_src_b(logic [3:0] op, reg_id_t fb);
    case (op)
      OP_STM, OP_LDM, OP_ALU:            return fb;
      OP_CALL, OP_RET, OP_PUSH, OP_POP:  return SP_ID;
      default:                           return ID_NONE;
    endcase
  endfunction

  function automatic reg_id_t pick_dst_e(logic [3:0] op, reg_id_t fb, logic cnd);
    case (op)
      OP_MOVC:                           return cnd ? fb : ID_NONE;
      OP_LDI, OP_ALU:                    return fb;
      OP_CALL, OP_RET, OP_PUSH, OP_POP:  return SP_ID;
      default:                           return ID_NONE;
    endcase
  endfunction

  function automatic reg_id_t pick_dst_m(logic [3:0] op, reg_id_t fa);
    case (op)
      OP_LDM, OP_POP: return fa;
      default:        return ID_NONE;
    endcase
  endfunction

endpackage

// File: rtl/gprf_decode.sv
module gprf_decode
  import gprf_pkg::*;
(
  input  logic [3:0] op_code,
  input  reg_id_t    fld_a,
  input  reg_id_t    fld_b,
  input  logic       cond_ok,
  output reg_id_t    src_a,
  output reg_id_t    src_b,
  output reg_id_t    dst_e,
  output reg_id_t    dst_m
);

  always_comb begin
    src_a = pick_src_a(op_code, fld_a);
    src_b = pick_src_b(op_code, fld_b);
    dst_e = pick_dst_e(op_code, fld_b, cond_ok);
    dst_m = pick_dst_m(op_code, fld_a);
  end

endmodule

// File: rtl/gprf_store.sv
module gprf_store #(
  parameter int DATA_W = 64,
  parameter int NREG   = 15,
  parameter int ID_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ID_W-1:0]   src_a,
  input  logic [ID_W-1:0]   src_b,
  input  logic [ID_W-1:0]   dst_e,
  input  logic [ID_W-1:0]   dst_m,
  input  logic [DATA_W-1:0] wd_e,
  input  logic [DATA_W-1:0] wd_m,
  output logic [DATA_W-1:0] rd_a,
  output logic [DATA_W-1:0] rd_b,
  output logic [NREG-1:0]   hit_e,
  output logic [NREG-1:0]   hit_m
);

  logic [DATA_W-1:0] cells [NREG];

  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DATA_W-1:0] q;
    assign hit_e[g] = (dst_e == ID_W'(g));
    assign hit_m[g] = (dst_m == ID_W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        q <= '0;
      else if (hit_m[g]) q <= wd_m;
      else if (hit_e[g]) q <= wd_e;
    end
    assign cells[g] = q;
  end

  function automatic logic [DATA_W-1:0] read_cell(logic [ID_W-1:0] id);
    if (32'(id) < NREG) return cells[id];
    return '0;
  endfunction

  always_comb begin
    rd_a = read_cell(src_a);
    rd_b = read_cell(src_b);
  end

endmodule

// File: rtl/gpr_file_sel.sv
module gpr_file_sel
  import gprf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NREG   = 15
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [3:0]        op_code,
  input  logic [3:0]        fld_a,
  input  logic [3:0]        fld_b,
  input  logic              cond_ok,
  input  logic [DATA_W-1:0] wdata_e,
  input  logic [DATA_W-1:0] wdata_m,
  output logic [DATA_W-1:0] rdata_a,
  output logic [DATA_W-1:0] rdata_b
);

  localparam int ID_W = $bits(reg_id_t);

  reg_id_t          src_a_id, src_b_id, dst_e_id, dst_m_id;
  logic [NREG-1:0]  wr_hit_e, wr_hit_m;

  gprf_decode u_dec (
    .op_code (op_code),
    .fld_a   (fld_a),
    .fld_b   (fld_b),
    .cond_ok (cond_ok),
    .src_a   (src_a_id),
    .src_b   (src_b_id),
    .dst_e   (dst_e_id),
    .dst_m   (dst_m_id)
  );

  gprf_store #(.DATA_W(DATA_W), .NREG(NREG), .ID_W(ID_W)) u_store (
    .clk   (clk),
    .rst_n (rst_n),
    .src_a (src_a_id),
    .src_b (src_b_id),
    .dst_e (dst_e_id),
    .dst_m (dst_m_id),
    .wd_e  (wdata_e),
    .wd_m  (wdata_m),
    .rd_a  (rdata_a),
    .rd_b  (rdata_b),
    .hit_e (wr_hit_e),
    .hit_m (wr_hit_m)
  );

endmodule

// File: rtl/gprf_checker.sv
module gprf_checker
  import gprf_pkg::*;
#(
  parameter int DATA_W = 64,
  parameter int NREG   = 15
) (
  input logic              clk,
  input logic              rst_n,
  input logic [3:0]        op_code,
  input logic              cond_ok,
  input logic [DATA_W-1:0] wdata_e,
  input logic [DATA_W-1:0] wdata_m,
  input logic [DATA_W-1:0] rdata_a,
  input logic [DATA_W-1:0] rdata_b,
  input reg_id_t           src_a_id,
  input reg_id_t           src_b_id,
  input reg_id_t           dst_e_id,
  input reg_id_t           dst_m_id,
  input logic [NREG-1:0]   wr_hit_e,
  input logic [NREG-1:0]   wr_hit_m
);

  a_r2_none_reads_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (src_a_id == ID_NONE) |-> (rdata_a == '0));

  a_r2_none_no_hit: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_e_id == ID_NONE && dst_m_id == ID_NONE) |-> (wr_hit_e == '0 && wr_hit_m == '0));

  a_r3_ret_uses_sp: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_RET) |-> (src_a_id == SP_ID && src_b_id == SP_ID && dst_e_id == SP_ID));

  a_r6_cmov_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (op_code == OP_MOVC && !cond_ok) |-> (wr_hit_e == '0));

  a_r6_one_target: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(wr_hit_e) && $onehot0(wr_hit_m));

  a_r6_e_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_e_id != ID_NONE && dst_e_id != dst_m_id) |=>
      (src_b_id != $past(dst_e_id) || rdata_b == $past(wdata_e)));

  a_r8_m_visible: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_m_id != ID_NONE) |=>
      (src_a_id != $past(dst_m_id) || rdata_a == $past(wdata_m)));

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (dst_e_id == ID_NONE && dst_m_id == ID_NONE) |=>
      (src_a_id != $past(src_a_id) || rdata_a == $past(rdata_a)));

endmodule

bind gpr_file_sel gprf_checker #(.DATA_W(DATA_W), .NREG(NREG)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .op_code  (op_code),
  .cond_ok  (cond_ok),
  .wdata_e  (wdata_e),
  .wdata_m  (wdata_m),
  .rdata_a  (rdata_a),
  .rdata_b  (rdata_b),
  .src_a_id (src_a_id),
  .src_b_id (src_b_id),
  .dst_e_id (dst_e_id),
  .dst_m_id (dst_m_id),
  .wr_hit_e (wr_hit_e),
  .wr_hit_m (wr_hit_m)
);

// File: tb/gpr_file_sel_tb.sv
module gpr_file_sel_tb;

  localparam int W = 64;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic [3:0]   op_code = 4'h1, fld_a = 4'hF, fld_b = 4'hF;
  logic         cond_ok = 1'b0;
  logic [W-1:0] wdata_e = '0, wdata_m = '0;
  logic [W-1:0] rdata_a, rdata_b;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;
  logic [W-1:0] model [15];

  always #10 clk = ~clk;

  gpr_file_sel u_dut (
    .clk(clk), .rst_n(rst_n), .op_code(op_code), .fld_a(fld_a), .fld_b(fld_b),
    .cond_ok(cond_ok), .wdata_e(wdata_e), .wdata_m(wdata_m),
    .rdata_a(rdata_a), .rdata_b(rdata_b)
  );

  // Bench's own restatement of the selection rules.
  function automatic logic [3:0] want_a(logic [3:0] op, logic [3:0] fa);
    if (op inside {4'h2, 4'h4, 4'h6, 4'hA}) return fa;
    if (op inside {4'h9, 4'hB}) return 4'd4;
    return 4'hF;
  endfunction

  function automatic logic [3:0] want_b(logic [3:0] op, logic [3:0] fb);
    if (op inside {4'h4, 4'h5, 4'h6}) return fb;
    if (op >= 4'h8 && op <= 4'hB) return 4'd4;
    return 4'hF;
  endfunction

  function automatic logic [3:0] want_e(logic [3:0] op, logic [3:0] fb, logic c);
    if (op == 4'h3 || op == 4'h6 || (op == 4'h2 && c)) return fb;
    if (op >= 4'h8 && op <= 4'hB) return 4'd4;
    return 4'hF;
  endfunction

  function automatic logic [3:0] want_m(logic [3:0] op, logic [3:0] fa);
    return (op == 4'h5 || op == 4'hB) ? fa : 4'hF;
  endfunction

  function automatic logic [W-1:0] peek(logic [3:0] id);
    return (id == 4'hF) ? '0 : model[id];
  endfunction

  task automatic chk(string tag, logic [W-1:0] act, logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Drive one instruction, check both reads in the same cycle, then
  // apply the writes of that cycle to the model (E first, M overrides).
  task automatic step(logic [3:0] op, logic [3:0] fa, logic [3:0] fb, logic c,
                      logic [W-1:0] ve, logic [W-1:0] vm, string ta, string tb);
    logic [3:0] de, dm;
    @(negedge clk);
    op_code = op; fld_a = fa; fld_b = fb; cond_ok = c; wdata_e = ve; wdata_m = vm;
    #3;
    chk(ta, rdata_a, peek(want_a(op, fa)));
    chk(tb, rdata_b, peek(want_b(op, fb)));
    de = want_e(op, fb, c);
    dm = want_m(op, fa);
    if (de != 4'hF) model[de] = ve;
    if (dm != 4'hF) model[dm] = vm;
  endtask

  task automatic probe(logic [3:0] ra, logic [3:0] rb, string tag);
    step(4'h4, ra, rb, 1'b0, {$urandom, $urandom}, {$urandom, $urandom}, tag, tag);
  endtask

  function automatic logic [W-1:0] rnd64();
    return {$urandom, $urandom};
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin : main
    void'($urandom(32'd2024));
    for (int i = 0; i < 15; i++) model[i] = '0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;

    // R1: every register clears at reset
    for (int i = 0; i < 15; i++) probe(4'(i), 4'(i), "R1");

    // R6: load-immediate into r3, then R5: visible on the next cycle
    step(4'h3, 4'hF, 4'd3, 1'b0, 64'hA1A1_0000_0000_0003, rnd64(), "R3", "R4");
    probe(4'd3, 4'd3, "R5");

    // R2: ALU op aimed at 0xF writes nothing; read of 0xF gives zero
    step(4'h6, 4'hF, 4'hF, 1'b0, 64'hDEAD_BEEF_0000_0001, rnd64(), "R2", "R2");
    probe(4'hF, 4'hF, "R2");
    for (int i = 0; i < 15; i++) probe(4'(i), 4'(i), "R9");

    // R6: conditional move blocked, then allowed
    step(4'h2, 4'd3, 4'd5, 1'b0, 64'h5555_0000_0000_0005, rnd64(), "R3", "R4");
    probe(4'd5, 4'd5, "R6");
    step(4'h2, 4'd3, 4'd5, 1'b1, 64'h5555_1111_0000_0005, rnd64(), "R3", "R4");
    probe(4'd5, 4'd5, "R6");

    // R7: memory load into r7 via port M
    step(4'h5, 4'd7, 4'd3, 1'b0, rnd64(), 64'h7777_0000_0000_0007, "R3", "R4");
    probe(4'd7, 4'd7, "R7");

    // R8: pop into the stack pointer; M value must win on r4
    step(4'hB, 4'd4, 4'hF, 1'b0, 64'hEEEE_0000_0000_0004, 64'h8888_0000_0000_0004, "R3", "R4");
    probe(4'd4, 4'd4, "R8");

    // R3/R4: push reads fld_a and the stack pointer; ret reads sp on both
    step(4'hA, 4'd7, 4'hF, 1'b0, 64'h0000_0000_0000_0FF8, rnd64(), "R3", "R4");
    step(4'h9, 4'd1, 4'd2, 1'b0, 64'h0000_0000_0000_1000, rnd64(), "R3", "R4");
    step(4'h8, 4'd1, 4'd2, 1'b0, 64'h0000_0000_0000_0FF0, rnd64(), "R3", "R4");
    probe(4'd4, 4'd4, "R6");

    // Random instruction mix, every field and code value
    for (int n = 0; n < 600; n++) begin
      step(4'($urandom), 4'($urandom), 4'($urandom), 1'($urandom),
           rnd64(), rnd64(), "R3", "R4");
    end
    for (int i = 0; i < 15; i++) probe(4'(i), 4'(14 - i), "R9");

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule